// File: doc/BRIEF.md
# Burst Transfer CRC Checker

This block sits on the receive side of a 16-bit parallel burst link. While a burst is open it keeps a running 16-bit CRC over every data word strobed in. The CRC is the remainder of modulo-2 division by the generator x^16 + x^12 + x^5 + 1. When the sender closes the burst, the block compares the CRC word the sender supplies with its own result. A mismatch raises two flags together in an 8-bit error register. A done pulse reports that the compare has happened, whether it matched or not.

Each burst restarts the running CRC from the fixed seed 16'h4ABA. No per-word parity is checked: the single CRC compare at the close of the burst is the only test of the data. The error flags hold their value across later bursts until the host clears them.

Top module: `burst_crc_check`

## Requirements
- R1: After reset, `err_reg_o` is 8'h00 and `done_o` is 0.
- R2: An accepted burst start loads the running CRC with 16'h4ABA. A burst closed with no words is compared against 16'h4ABA.
- R3: Each accepted word folds all 16 bits into the CRC in one cycle, most significant bit first, with generator 16'h1021 (x^16+x^12+x^5+1). There is no bit reflection and no final inversion. Only data words enter the CRC.
- R4: If the received CRC differs from the local CRC at burst end, bit 7 (interface CRC error) and bit 2 (abort) of `err_reg_o` are both set at the same clock edge. The other six bits stay 0.
- R5: `done_o` is high for exactly one cycle. That cycle is the one after an accepted burst end, whether the compare matched or not.
- R6: The error bits stay set until `err_clear_i` is asserted. A clear with no mismatch returns the register to 8'h00. A mismatch in the same cycle as a clear leaves the bits set.
- R7: A burst start while a burst is open discards the partial CRC and restarts from the seed.
- R8: Word strobes and burst-end strobes outside an open burst are ignored. They cause no done pulse, no error change and no effect on the next burst.
- R9: Burst start takes precedence over a word or a burst end in the same cycle: that word is not folded in and that end is not compared. A word strobed in the same cycle as an accepted burst end is not folded in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_start_i | input | 1 | Opens (or reopens) a burst |
| word_valid_i | input | 1 | Data word strobe |
| word_data_i | input | 16 | Data word |
| burst_end_i | input | 1 | Closes the burst and presents the sender CRC |
| rx_crc_i | input | 16 | CRC word from the sender, valid with `burst_end_i` |
| err_clear_i | input | 1 | Clears the error register |
| err_reg_o | output | 8 | Error register (bit 7 CRC error, bit 2 abort) |
| done_o | output | 1 | One-cycle pulse after each compare |

## Verification
A wrong CRC state is hidden until a burst closes. It then appears as 8'h84 in `err_reg_o` together with the done pulse, one cycle after the end strobe. For that reason the sweeps close a burst after every stimulus pattern and supply the CRC that the bench computes itself. A bad seed, fold or word-gating bug therefore shows within one cycle of the next compare. A state fault in the control path appears as a missing or extra done pulse, or as flags that fail to stick or fail to clear.

// File: rtl/burst_crc_pkg.sv
package burst_crc_pkg;

  localparam int CRC_W  = 16;
  localparam int DATA_W = 16;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic {
    LINK_IDLE   = 1'b0,
    LINK_ACTIVE = 1'b1
  } link_state_e;

  // One word folded into the remainder, MSB first, one bit step per loop pass.
  function automatic crc_t crc_fold(input crc_t cur, input word_t din, input crc_t poly);
    crc_t r;
    logic fb;
    r = cur;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ din[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

endpackage

// File: rtl/burst_link_fsm.sv
module burst_link_fsm
  import burst_crc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic word_i,
  input  logic end_i,
  output logic seed_load_o,
  output logic fold_en_o,
  output logic cmp_en_o
);

  link_state_e state_q, state_d;
  logic        open_w;

  assign open_w      = (state_q == LINK_ACTIVE);
  assign seed_load_o = start_i;
  assign fold_en_o   = open_w && word_i && !start_i && !end_i;
  assign cmp_en_o    = open_w && end_i && !start_i;

  always_comb begin
    state_d = state_q;
    if (start_i)       state_d = LINK_ACTIVE;
    else if (cmp_en_o) state_d = LINK_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LINK_IDLE;
    else        state_q <= state_d;
  end

  // R7 / R9: a start always leaves the link open
  assert_start_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_q == LINK_ACTIVE));

  // R5: a compare always closes the burst
  assert_compare_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en_o |=> (state_q == LINK_IDLE));

  // R8: an idle link without start stays idle whatever else strobes
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_w && !start_i) |=> (state_q == LINK_IDLE));

endmodule

// File: rtl/crc_accum.sv
module crc_accum
  import burst_crc_pkg::*;
#(
  parameter crc_t POLY = 16'h1021,
  parameter crc_t SEED = 16'h4ABA
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  seed_load_i,
  input  logic  fold_en_i,
  input  word_t data_i,
  output crc_t  crc_o
);

  crc_t crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= SEED;
    else if (seed_load_i) crc_q <= SEED;
    else if (fold_en_i)  crc_q <= crc_fold(crc_q, data_i, POLY);
  end

  assign crc_o = crc_q;

  // R2: start reloads the seed
  assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load_i |=> (crc_q == SEED));

  // R8 / R9: without a fold or start the remainder is untouched
  assert_crc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load_i && !fold_en_i) |=> $stable(crc_q));

endmodule

// File: rtl/crc_err_flags.sv
module crc_err_flags
  import burst_crc_pkg::*;
#(
  parameter int ERR_W       = 8,
  parameter int CRC_ERR_BIT = 7,
  parameter int ABORT_BIT   = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_en_i,
  input  crc_t             local_crc_i,
  input  crc_t             rx_crc_i,
  input  logic             clear_i,
  output logic [ERR_W-1:0] err_o,
  output logic             done_o
);

  logic             mismatch_w;
  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] err_d;
  logic             done_q;

  assign mismatch_w = cmp_en_i && (local_crc_i != rx_crc_i);

  for (genvar b = 0; b < ERR_W; b++) begin : g_bit
    if (b == CRC_ERR_BIT || b == ABORT_BIT) begin : g_flag
      assign err_d[b] = (err_q[b] && !clear_i) || mismatch_w;
    end else begin : g_zero
      assign err_d[b] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      done_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      done_q <= cmp_en_i;
    end
  end

  assign err_o  = err_q;
  assign done_o = done_q;

  // R4: both flags move together
  assert_flag_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q[CRC_ERR_BIT] == err_q[ABORT_BIT]);

  // R4: a mismatch shows up at the next edge
  assert_mismatch_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_w |=> err_q[CRC_ERR_BIT]);

  // R6: sticky until clear
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[CRC_ERR_BIT] && !clear_i) |=> err_q[CRC_ERR_BIT]);

  // R6: clear without new mismatch empties the register
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !mismatch_w) |=> (err_q == '0));

  // R5: done follows every compare and lasts one cycle
  assert_done_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en_i |=> done_q);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/burst_crc_check.sv
module burst_crc_check
  import burst_crc_pkg::*;
#(
  parameter logic [15:0] POLY        = 16'h1021,
  parameter logic [15:0] SEED        = 16'h4ABA,
  parameter int          ERR_W       = 8,
  parameter int          CRC_ERR_BIT = 7,
  parameter int          ABORT_BIT   = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start_i,
  input  logic             word_valid_i,
  input  logic [15:0]      word_data_i,
  input  logic             burst_end_i,
  input  logic [15:0]      rx_crc_i,
  input  logic             err_clear_i,
  output logic [ERR_W-1:0] err_reg_o,
  output logic             done_o
);

  logic seed_load_w;
  logic fold_en_w;
  logic cmp_en_w;
  crc_t run_crc_w;

  burst_link_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (burst_start_i),
    .word_i      (word_valid_i),
    .end_i       (burst_end_i),
    .seed_load_o (seed_load_w),
    .fold_en_o   (fold_en_w),
    .cmp_en_o    (cmp_en_w)
  );

  crc_accum #(.POLY(POLY), .SEED(SEED)) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .seed_load_i (seed_load_w),
    .fold_en_i   (fold_en_w),
    .data_i      (word_data_i),
    .crc_o       (run_crc_w)
  );

  crc_err_flags #(
    .ERR_W(ERR_W), .CRC_ERR_BIT(CRC_ERR_BIT), .ABORT_BIT(ABORT_BIT)
  ) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_en_i    (cmp_en_w),
    .local_crc_i (run_crc_w),
    .rx_crc_i    (rx_crc_i),
    .clear_i     (err_clear_i),
    .err_o       (err_reg_o),
    .done_o      (done_o)
  );

  // R8: a lone end strobe outside a burst never produces done
  assert_no_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en_w) |=> !done_o);

endmodule

// File: tb/test_burst_crc_check.sv
module test_burst_crc_check;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SEED_V = 16'h4ABA;
  localparam logic [7:0]  ERR_V  = 8'h84;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burst_start_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [15:0] word_data_i = '0;
  logic        burst_end_i = 1'b0;
  logic [15:0] rx_crc_i = '0;
  logic        err_clear_i = 1'b0;
  logic [7:0]  err_reg_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_crc_check i_burst_crc_check (
    .clk(clk), .rst_n(rst_n),
    .burst_start_i(burst_start_i), .word_valid_i(word_valid_i),
    .word_data_i(word_data_i), .burst_end_i(burst_end_i),
    .rx_crc_i(rx_crc_i), .err_clear_i(err_clear_i),
    .err_reg_o(err_reg_o), .done_o(done_o)
  );

  // Long division of {crc^word, 16 zeros} by the 17-bit generator 0x11021.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
    logic [31:0] x;
    x = {c ^ d, 16'h0000};
    for (int i = 31; i >= 16; i--)
      if (x[i]) x = x ^ (32'h0001_1021 << (i - 16));
    return x[15:0];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs from a negedge; returns at the following negedge.
  task automatic cyc(input logic s, input logic w, input logic [15:0] d,
                     input logic e, input logic [15:0] rx, input logic clr);
    burst_start_i = s; word_valid_i = w; word_data_i = d;
    burst_end_i = e; rx_crc_i = rx; err_clear_i = clr;
    @(negedge clk);
    burst_start_i = 0; word_valid_i = 0; word_data_i = '0;
    burst_end_i = 0; rx_crc_i = '0; err_clear_i = 0;
  endtask

  task automatic close_and_check(input string tag, input logic [15:0] rx, input logic [7:0] exp_err);
    cyc(0, 0, 16'h0, 1, rx, 0);
    chk({tag, " done"}, {15'h0, done_o}, 16'h1);
    chk({tag, " err"}, {8'h0, err_reg_o}, {8'h0, exp_err});
    @(negedge clk);
    chk({tag, " done_once R5"}, {15'h0, done_o}, 16'h0);
  endtask

  task automatic do_clear(input string tag);
    cyc(0, 0, 16'h0, 0, 16'h0, 1);
    chk({tag, " clear R6"}, {8'h0, err_reg_o}, 16'h0);
  endtask

  initial begin
    logic [15:0] c;
    logic [15:0] c2;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk("R1 reset err", {8'h0, err_reg_o}, 16'h0);
    chk("R1 reset done", {15'h0, done_o}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: empty bursts
    cyc(1, 0, 0, 0, 0, 0);
    close_and_check("R2 empty match", SEED_V, 8'h00);
    cyc(1, 0, 0, 0, 0, 0);
    close_and_check("R2/R4 empty mismatch", 16'h0000, ERR_V);
    do_clear("R2");

    // R3: single-word sweep, with a one-bit corrupted CRC every 16th value
    for (int v = 0; v < 256; v++) begin
      d = {v[7:0], v[7:0] ^ 8'h5A};
      c = ref_crc(SEED_V, d);
      cyc(1, 0, 0, 0, 0, 0);
      cyc(0, 1, d, 0, 0, 0);
      close_and_check("R3 single word", c, 8'h00);
      if (v % 16 == 0) begin
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 1, d, 0, 0, 0);
        close_and_check("R4 flipped crc", c ^ (16'h1 << (v / 16)), ERR_V);
        do_clear("R4");
      end
    end

    // R3: walking-one words inside one long burst
    c = SEED_V;
    cyc(1, 0, 0, 0, 0, 0);
    for (int b = 0; b < 16; b++) begin
      cyc(0, 1, 16'h1 << b, 0, 0, 0);
      c = ref_crc(c, 16'h1 << b);
    end
    close_and_check("R3 walking burst", c, 8'h00);

    // R6: sticky across a matching burst, clear vs set in one cycle
    cyc(1, 0, 0, 0, 0, 0);
    close_and_check("R6 set", 16'h1234, ERR_V);
    cyc(1, 0, 0, 0, 0, 0);
    close_and_check("R6 sticky", SEED_V, ERR_V);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 16'hBEEF, 1);
    chk("R6 set beats clear", {8'h0, err_reg_o}, {8'h0, ERR_V});
    do_clear("R6");

    // R7: restart discards partial CRC
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 16'hAAAA, 0, 0, 0);
    cyc(0, 1, 16'h5555, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 16'hC3C3, 0, 0, 0);
    close_and_check("R7 restart", ref_crc(SEED_V, 16'hC3C3), 8'h00);

    // R8: strobes outside a burst
    cyc(0, 0, 0, 1, 16'h0000, 0);
    chk("R8 idle end no done", {15'h0, done_o}, 16'h0);
    chk("R8 idle end no err", {8'h0, err_reg_o}, 16'h0);
    cyc(0, 1, 16'hFFFF, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    close_and_check("R8 idle word ignored", SEED_V, 8'h00);

    // R9: start wins over word; end cycle takes no word
    cyc(1, 1, 16'h9999, 0, 0, 0);
    close_and_check("R9 start+word", SEED_V, 8'h00);
    c2 = ref_crc(SEED_V, 16'h0F0F);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 16'h0F0F, 0, 0, 0);
    cyc(0, 1, 16'h7777, 1, c2, 0);
    chk("R9 end+word done", {15'h0, done_o}, 16'h1);
    chk("R9 end+word err", {8'h0, err_reg_o}, 16'h0);
    cyc(1, 0, 0, 1, 16'h0000, 0);
    chk("R9 start+end no compare", {15'h0, done_o}, 16'h0);
    close_and_check("R9 still open", SEED_V, 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule